// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR3 memory interface. It drives the reset, clock-enable and command/address pins through the mandatory power-up sequence. Once the supply is reported good, the sequencer runs these steps in order:

1. It holds the memory in reset.
2. It releases reset while clock enable stays low.
3. It raises clock enable and waits out the exit-reset interval.
4. It writes the four mode registers in a fixed order.
5. It issues a long ZQ calibration and waits for it to complete.

When the last wait expires, `init_done` rises and normal traffic may start.

Wait intervals given in nanoseconds (reset hold, clock-enable hold, exit-reset interval) are turned into clock counts from the clock period parameter. The mode-register gap, the mode-to-command delay and the calibration wait are parameters given directly in clocks. These three must be at least 2. Every cycle that carries no mode-register write or calibration command is filled with a deselect (clock enable low) or a NOP (clock enable high). ODT is held low throughout. If the power-good input drops at any point, the sequence restarts from the reset hold on the next clock.

Top module: `ddr3_pwrup_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it, the outputs are as follows:
  - `ddr_reset_n`, `ddr_cke` and `init_done` are 0.
  - The command pins show a deselect: `ddr_cs_n`, `ddr_ras_n`, `ddr_cas_n` and `ddr_we_n` are all 1, with `ddr_ba` and `ddr_addr` 0.
- R2: Counting rising edges with `pwr_good` high since it was last low or `rst` was last high, `ddr_reset_n` stays 0 for the first RST_CYC-1 edges and becomes 1 after edge RST_CYC. RST_CYC is RST_HOLD_NS rounded up to whole clocks.
- R3: `ddr_cke` is 0 whenever `ddr_reset_n` is 0. It stays 0 for CKE_CYC further clocks after reset release, while a deselect is driven.
- R4: After `ddr_cke` rises, XPR_CYC clocks of NOP follow before the first mode-register write. NOP is cs/ras/cas/we = 0,1,1,1 with BA and address 0.
- R5: The mode-register writes use command code 0,0,0,0. They come in the order MR2, MR3, MR1, MR0, and each write carries its register number on `ddr_ba` and the matching `mrN_val` on `ddr_addr`.
- R6: Successive mode-register writes are exactly TMRD_CYC clocks apart.
- R7: A long ZQ calibration follows the MR0 write by exactly TMOD_CYC clocks. It is command code 0,1,1,0, with address bit 10 set and all other address bits and BA zero.
- R8: `init_done` rises exactly TZQINIT_CYC clocks after the calibration command and stays high while `pwr_good` stays high.
- R9: Between the first mode-register write and `init_done`, every cycle other than the four writes and the calibration carries a NOP.
- R10: A clock edge with `pwr_good` low returns the block to the reset hold: the next cycle shows R1's output values, and the sequence restarts from R2.
- R11: `ddr_odt` is 0 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supply stable indication |
| mr0_val | input | 15 | Opcode written to MR0 |
| mr1_val | input | 15 | Opcode written to MR1 |
| mr2_val | input | 15 | Opcode written to MR2 |
| mr3_val | input | 15 | Opcode written to MR3 |
| ddr_reset_n | output | 1 | Memory reset, active low |
| ddr_cke | output | 1 | Clock enable |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | 3 | Bank address / mode-register select |
| ddr_addr | output | 15 | Address / mode opcode |
| ddr_odt | output | 1 | On-die termination control |
| init_done | output | 1 | Sequence complete |

## Verification
The interesting overlap is a power-good drop landing on the same edge as a sequencing step. Such a step can be a mode-register write, the calibration command or the cycle in which `init_done` would rise, and the restart must win over it. The bench schedules directed drops on exactly those edges and adds randomly placed drops of random length. It checks every cycle against a model that follows only the edge count since power-good last returned.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;

    localparam int DDR_ADDR_W = 15;
    localparam int DDR_BA_W   = 3;
    localparam int MR_COUNT   = 4;
    localparam int STEP_W     = $clog2(MR_COUNT);
    localparam int ZQ_LONG_BIT = 10;

    typedef enum logic [2:0] {
        ST_RST_HOLD,
        ST_CKE_WAIT,
        ST_XPR,
        ST_MRS,
        ST_GAP,
        ST_ZQCL,
        ST_ZQ_WAIT,
        ST_DONE
    } init_state_t;

    typedef struct packed {
        logic                  cs_n;
        logic                  ras_n;
        logic                  cas_n;
        logic                  we_n;
        logic [DDR_BA_W-1:0]   ba;
        logic [DDR_ADDR_W-1:0] addr;
    } ddr_cmd_t;

    // Builds a command word from a cs/ras/cas/we code with BA and address zero.
    function automatic ddr_cmd_t make_cmd(logic [3:0] code);
        ddr_cmd_t c;
        {c.cs_n, c.ras_n, c.cas_n, c.we_n} = code;
        c.ba   = '0;
        c.addr = '0;
        return c;
    endfunction

    localparam logic [3:0] CODE_DES = 4'b1111;
    localparam logic [3:0] CODE_NOP = 4'b0111;
    localparam logic [3:0] CODE_MRS = 4'b0000;
    localparam logic [3:0] CODE_ZQ  = 4'b0110;

    // Load step -> mode register number (order MR2, MR3, MR1, MR0).
    function automatic logic [STEP_W-1:0] mr_target(logic [STEP_W-1:0] step);
        case (step)
            2'd0:    return 2'd2;
            2'd1:    return 2'd3;
            2'd2:    return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

    // Rounds a nanosecond interval up to whole clocks.
    function automatic int ns_to_cyc(int ns, int clk_ps);
        return (ns * 1000 + clk_ps - 1) / clk_ps;
    endfunction

endpackage

// File: rtl/ddr3_init_timer.sv
module ddr3_init_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/ddr3_init_cmd.sv
module ddr3_init_cmd
    import ddr3_init_pkg::*;
(
    input  init_state_t                            state,
    input  logic [STEP_W-1:0]                      step,
    input  logic [MR_COUNT-1:0][DDR_ADDR_W-1:0]    mr_vals,
    output ddr_cmd_t                               cmd,
    output logic                                   reset_n,
    output logic                                   cke,
    output logic                                   done
);
    logic [STEP_W-1:0] target;

    always_comb begin
        target  = mr_target(step);
        cmd     = make_cmd(CODE_NOP);
        reset_n = 1'b1;
        cke     = 1'b1;
        done    = 1'b0;
        case (state)
            ST_RST_HOLD: begin
                reset_n = 1'b0;
                cke     = 1'b0;
                cmd     = make_cmd(CODE_DES);
            end
            ST_CKE_WAIT: begin
                cke = 1'b0;
                cmd = make_cmd(CODE_DES);
            end
            ST_MRS: begin
                cmd      = make_cmd(CODE_MRS);
                cmd.ba   = DDR_BA_W'(target);
                cmd.addr = mr_vals[target];
            end
            ST_ZQCL: begin
                cmd = make_cmd(CODE_ZQ);
                cmd.addr[ZQ_LONG_BIT] = 1'b1;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/ddr3_pwrup_seq.sv
module ddr3_pwrup_seq
    import ddr3_init_pkg::*;
#(
    parameter int CLK_PS      = 1250,
    parameter int RST_HOLD_NS = 200000,
    parameter int CKE_HOLD_NS = 500000,
    parameter int TXPR_NS     = 170,
    parameter int TMRD_CYC    = 4,
    parameter int TMOD_CYC    = 12,
    parameter int TZQINIT_CYC = 512
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pwr_good,
    input  logic [DDR_ADDR_W-1:0] mr0_val,
    input  logic [DDR_ADDR_W-1:0] mr1_val,
    input  logic [DDR_ADDR_W-1:0] mr2_val,
    input  logic [DDR_ADDR_W-1:0] mr3_val,
    output logic                  ddr_reset_n,
    output logic                  ddr_cke,
    output logic                  ddr_cs_n,
    output logic                  ddr_ras_n,
    output logic                  ddr_cas_n,
    output logic                  ddr_we_n,
    output logic [DDR_BA_W-1:0]   ddr_ba,
    output logic [DDR_ADDR_W-1:0] ddr_addr,
    output logic                  ddr_odt,
    output logic                  init_done
);
    localparam int RST_CYC = ns_to_cyc(RST_HOLD_NS, CLK_PS);
    localparam int CKE_CYC = ns_to_cyc(CKE_HOLD_NS, CLK_PS);
    localparam int XPR_CYC = ns_to_cyc(TXPR_NS, CLK_PS);
    localparam int MAX_A   = (RST_CYC > CKE_CYC) ? RST_CYC : CKE_CYC;
    localparam int MAX_B   = (XPR_CYC > TZQINIT_CYC) ? XPR_CYC : TZQINIT_CYC;
    localparam int MAX_C   = (TMOD_CYC > TMRD_CYC) ? TMOD_CYC : TMRD_CYC;
    localparam int MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int LONGEST = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
    localparam int CNT_W   = $clog2(LONGEST + 1);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(MR_COUNT - 1);

    init_state_t       state, state_nx;
    logic [STEP_W-1:0] step, step_nx;
    logic              t_zero, t_load;
    logic [CNT_W-1:0]  t_val;
    ddr_cmd_t          cmd;
    logic [MR_COUNT-1:0][DDR_ADDR_W-1:0] mr_vals;

    assign mr_vals = {mr3_val, mr2_val, mr1_val, mr0_val};

    // Cycles spent in a state once entered.
    function automatic int dwell(init_state_t s, logic [STEP_W-1:0] st);
        case (s)
            ST_RST_HOLD: return RST_CYC;
            ST_CKE_WAIT: return CKE_CYC;
            ST_XPR:      return XPR_CYC;
            ST_GAP:      return (st == LAST_STEP) ? TMOD_CYC - 1 : TMRD_CYC - 1;
            ST_ZQ_WAIT:  return TZQINIT_CYC - 1;
            default:     return 1;
        endcase
    endfunction

    always_comb begin
        state_nx = state;
        step_nx  = step;
        if (!pwr_good) begin
            state_nx = ST_RST_HOLD;
            step_nx  = '0;
        end else begin
            case (state)
                ST_RST_HOLD: if (t_zero) state_nx = ST_CKE_WAIT;
                ST_CKE_WAIT: if (t_zero) state_nx = ST_XPR;
                ST_XPR:      if (t_zero) state_nx = ST_MRS;
                ST_MRS:      state_nx = ST_GAP;
                ST_GAP: if (t_zero) begin
                    if (step == LAST_STEP) begin
                        state_nx = ST_ZQCL;
                    end else begin
                        state_nx = ST_MRS;
                        step_nx  = step + 1'b1;
                    end
                end
                ST_ZQCL:     state_nx = ST_ZQ_WAIT;
                ST_ZQ_WAIT:  if (t_zero) state_nx = ST_DONE;
                default:     state_nx = ST_DONE;
            endcase
        end
        t_load = rst || !pwr_good || (state_nx != state);
        t_val  = rst ? CNT_W'(RST_CYC - 1) : CNT_W'(dwell(state_nx, step_nx) - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RST_HOLD;
            step  <= '0;
        end else begin
            state <= state_nx;
            step  <= step_nx;
        end
    end

    ddr3_init_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    ddr3_init_cmd u_cmd (
        .state   (state),
        .step    (step),
        .mr_vals (mr_vals),
        .cmd     (cmd),
        .reset_n (ddr_reset_n),
        .cke     (ddr_cke),
        .done    (init_done)
    );

    assign ddr_cs_n  = cmd.cs_n;
    assign ddr_ras_n = cmd.ras_n;
    assign ddr_cas_n = cmd.cas_n;
    assign ddr_we_n  = cmd.we_n;
    assign ddr_ba    = cmd.ba;
    assign ddr_addr  = cmd.addr;
    assign ddr_odt   = 1'b0;
endmodule

// File: rtl/ddr3_pwrup_chk.sv
module ddr3_pwrup_chk #(
    parameter int MRD_CYC = 4,
    parameter int MOD_CYC = 12
) (
    input logic clk,
    input logic rst,
    input logic pwr_good,
    input logic ddr_reset_n,
    input logic ddr_cke,
    input logic ddr_cs_n,
    input logic ddr_ras_n,
    input logic ddr_cas_n,
    input logic ddr_we_n,
    input logic init_done
);
    logic [3:0]  code;
    logic        is_mrs, is_zq, is_nop, is_des;
    logic [15:0] since;
    logic [2:0]  mrs_seen;

    assign code   = {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n};
    assign is_mrs = (code == 4'b0000);
    assign is_zq  = (code == 4'b0110);
    assign is_nop = (code == 4'b0111);
    assign is_des = ddr_cs_n;

    always_ff @(posedge clk) begin
        if (rst || !ddr_reset_n) begin
            since    <= '0;
            mrs_seen <= '0;
        end else if (is_mrs) begin
            since    <= 16'd1;
            mrs_seen <= (mrs_seen == 3'd4) ? mrs_seen : mrs_seen + 3'd1;
        end else if (since != 16'hFFFF) begin
            since <= since + 16'd1;
        end
    end

    // R3
    cke_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
        !ddr_reset_n |-> !ddr_cke);

    // R4
    cke_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ddr_cke) |-> (ddr_reset_n && $past(ddr_reset_n)));

    // R6
    mrd_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (is_mrs && mrs_seen != 3'd0) |-> (since == 16'(MRD_CYC)));

    // R7
    zq_after_mod_chk: assert property (@(posedge clk) disable iff (rst)
        is_zq |-> (mrs_seen == 3'd4 && since == 16'(MOD_CYC)));

    // R9
    legal_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        ddr_cke |-> (is_nop || is_mrs || is_zq));

    // R3
    des_when_cke_low_chk: assert property (@(posedge clk) disable iff (rst)
        !ddr_cke |-> is_des);

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (init_done && pwr_good) |=> init_done);

    // R10
    pwr_loss_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_good |=> (!ddr_reset_n && !ddr_cke && !init_done));
endmodule

bind ddr3_pwrup_seq ddr3_pwrup_chk #(
    .MRD_CYC (TMRD_CYC),
    .MOD_CYC (TMOD_CYC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pwr_good    (pwr_good),
    .ddr_reset_n (ddr_reset_n),
    .ddr_cke     (ddr_cke),
    .ddr_cs_n    (ddr_cs_n),
    .ddr_ras_n   (ddr_ras_n),
    .ddr_cas_n   (ddr_cas_n),
    .ddr_we_n    (ddr_we_n),
    .init_done   (init_done)
);

// File: tb/ddr3_pwrup_seq_bench.sv
module ddr3_pwrup_seq_bench;
    localparam int CLK_PS = 4000;
    localparam int RST_NS = 200;
    localparam int CKE_NS = 400;
    localparam int XPR_NS = 40;
    localparam int MRD    = 4;
    localparam int MOD    = 12;
    localparam int ZQ     = 512;

    // Independent expectations in clocks (ceil of ns / period).
    localparam int R_C   = (RST_NS * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int C_C   = (CKE_NS * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int X_C   = (XPR_NS * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int K_MRS = R_C + C_C + X_C;
    localparam int K_ZQ  = K_MRS + 3 * MRD + MOD;
    localparam int K_END = K_ZQ + ZQ;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_good = 1'b0;
    logic [14:0] mr0_val = '0, mr1_val = '0, mr2_val = '0, mr3_val = '0;
    logic ddr_reset_n, ddr_cke, ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n;
    logic [2:0]  ddr_ba;
    logic [14:0] ddr_addr;
    logic ddr_odt, init_done;

    int n_vec  = 0;
    int n_fail = 0;
    int k      = 0;

    always #2ns clk = ~clk;

    ddr3_pwrup_seq #(
        .CLK_PS(CLK_PS), .RST_HOLD_NS(RST_NS), .CKE_HOLD_NS(CKE_NS),
        .TXPR_NS(XPR_NS), .TMRD_CYC(MRD), .TMOD_CYC(MOD), .TZQINIT_CYC(ZQ)
    ) u_ddr3_pwrup_seq (
        .clk(clk), .rst(rst), .pwr_good(pwr_good),
        .mr0_val(mr0_val), .mr1_val(mr1_val), .mr2_val(mr2_val), .mr3_val(mr3_val),
        .ddr_reset_n(ddr_reset_n), .ddr_cke(ddr_cke), .ddr_cs_n(ddr_cs_n),
        .ddr_ras_n(ddr_ras_n), .ddr_cas_n(ddr_cas_n), .ddr_we_n(ddr_we_n),
        .ddr_ba(ddr_ba), .ddr_addr(ddr_addr), .ddr_odt(ddr_odt), .init_done(init_done)
    );

    // Vector layout: {reset_n, cke, cs/ras/cas/we, ba[2:0], addr[14:0], odt, done}
    function automatic logic [25:0] exp_vec(int kk, logic [3:0][14:0] m);
        logic [3:0]  code = 4'b0111;
        logic [2:0]  ba   = '0;
        logic [14:0] ad   = '0;
        logic        rn = 1'b1, ck = 1'b1, dn = 1'b0;
        if (kk < R_C) begin
            rn = 1'b0; ck = 1'b0; code = 4'b1111;
        end else if (kk < R_C + C_C) begin
            ck = 1'b0; code = 4'b1111;
        end else if (kk >= K_MRS && kk <= K_MRS + 3 * MRD && (kk - K_MRS) % MRD == 0) begin
            code = 4'b0000;
            case ((kk - K_MRS) / MRD)
                0: ba = 3'd2;
                1: ba = 3'd3;
                2: ba = 3'd1;
                default: ba = 3'd0;
            endcase
            ad = m[ba[1:0]];
        end else if (kk == K_ZQ) begin
            code = 4'b0110; ad = 15'h0400;
        end else if (kk >= K_END) begin
            dn = 1'b1;
        end
        return {rn, ck, code, ba, ad, 1'b0, dn};
    endfunction

    function automatic string req_of(int kk, bit after_drop);
        if (after_drop && kk == 0) return "R10";
        if (kk < R_C)           return "R2";
        if (kk < R_C + C_C)     return "R3";
        if (kk < K_MRS)         return "R4";
        if (kk <= K_MRS + 3 * MRD && (kk - K_MRS) % MRD == 0) return "R5";
        if (kk < K_ZQ)          return "R6";
        if (kk == K_ZQ)         return "R7";
        if (kk < K_END)         return "R9";
        return "R8";
    endfunction

    function automatic logic [25:0] act_vec();
        return {ddr_reset_n, ddr_cke, ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n,
                ddr_ba, ddr_addr, ddr_odt, init_done};
    endfunction

    task automatic check(string tag, logic [25:0] exp);
        logic [25:0] act = act_vec();
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s k=%0d actual=%h expected=%h", tag, k, act, exp);
        end
        n_vec++;
        if (ddr_odt !== 1'b0) begin  // R11
            n_fail++;
            $display("FAIL R11 odt actual=%b expected=0", ddr_odt);
        end
    endtask

    // One clock: inputs already driven; update edge count, sample at negedge.
    task automatic step(bit after_drop);
        @(posedge clk);
        if (rst || !pwr_good) k = 0;
        else k = k + 1;
        @(negedge clk);
        check(req_of(k, after_drop), exp_vec(k, {mr3_val, mr2_val, mr1_val, mr0_val}));
    endtask

    // Full sequence, optionally with a power-good drop when k reaches drop_at.
    task automatic run(int drop_at, int drop_len);
        bit dropped = 0;
        mr0_val = 15'($urandom); mr1_val = 15'($urandom);
        mr2_val = 15'($urandom); mr3_val = 15'($urandom);
        pwr_good = 1'b0;
        step(1);
        pwr_good = 1'b1;
        while (k < K_END + 20) begin
            if (!dropped && drop_at >= 0 && k == drop_at - 1) begin
                dropped  = 1;
                pwr_good = 1'b0;
                for (int i = 0; i < drop_len; i++) step(1);
                pwr_good = 1'b1;
            end else begin
                step(0);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240607));
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 3; i++) step(0);
        check("R1", exp_vec(0, '0));
        rst = 1'b0;
        pwr_good = 1'b1;
        run(-1, 0);                 // plain sequence
        run(K_MRS, 3);              // R10 drop on first mode write edge
        run(K_MRS + 2 * MRD, 1);    // R10 drop on third mode write edge
        run(K_ZQ, 2);               // R10 drop on calibration edge
        run(K_END, 4);              // R10 drop on the edge init_done would rise
        run(K_END + 5, 2);          // R8/R10 drop after completion
        run(R_C / 2, 5);            // R2 drop during reset hold
        for (int r = 0; r < 4; r++)
            run(int'($urandom_range(1, K_END + 10)), int'($urandom_range(1, 6)));
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule